// File: doc/BRIEF.md
# Packet-Granular Shared Bus Arbiter

This unit controls a shared bus used by a configurable number of attached modules. Each module has its own request wire and its own grant wire. When the bus is free, the unit takes a snapshot of all pending requests. It then resolves that snapshot by fixed priority in a three-step sequence and raises exactly one grant.

The granted module keeps the bus for its whole packet. It gives the bus back by lowering its request after the last word. The unit then returns to idle and arbitrates again on the following cycle.

While a module owns the bus, it drives a destination address onto a shared address input. The unit decodes that address into one-hot select lines, one per attached module, so that the target sees that it is being addressed.

Top module: `bpa_bus_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all grant and select outputs are low after that edge, and any ownership in progress is dropped.
- R2: A request that is seen on the idle bus at clock edge k raises the winner's grant after edge k+3, and not earlier. The grant stays low after edges k, k+1 and k+2.
- R3: When several requests are present in the same snapshot, the lowest module index wins.
- R4: While a module holds a grant and keeps its request high, the grant does not move, even if a higher-priority module starts requesting.
- R5: At most one grant bit is high at any time, and all grants are low while no arbitration has completed.
- R6: When the owner's request is low at a clock edge, its grant drops after that edge. The next edge samples requests again for a new arbitration.
- R7: While a grant is active, select bit j is high exactly when the shared address equals j (binary code, j from 0 to N_PORTS-1). All select bits are low while no grant is active.
- R8: An address value of N_PORTS or above selects no module.
- R9: Requests that change after the snapshot edge have no effect on the arbitration in progress. A higher-priority request that arrives during the three-cycle sequence does not win it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_PORTS | One request wire per attached module; held high for the length of a packet |
| bus_addr_i | input | ADDR_W | Destination address driven by the current owner |
| grant_o | output | N_PORTS | One grant wire per attached module; at most one high |
| dest_sel_o | output | N_PORTS | One-hot destination select decoded from the address |

## Verification
The bench builds the block with its default values: seven ports and a three-bit address. With this setup the address space holds one code (7) that matches no module, which exercises the out-of-range decode. Seven request lines are enough to test simultaneous requests at the top, middle and bottom of the priority order. A behavioural model steps alongside the design on every clock. It checks the exact latency edge, that a higher-priority request cannot take over in the middle of a packet, and that a request arriving during an arbitration is ignored for that arbitration.

// File: rtl/bpa_pkg.sv
// Shared types for the packet bus arbiter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bpa_pkg;
    // Arbitration sequence: snapshot, pick, build, issue, then ownership.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PICK  = 3'd1,
        ST_BUILD = 3'd2,
        ST_ISSUE = 3'd3,
        ST_OWN   = 3'd4
    } arb_st_e;
endpackage

// File: rtl/bpa_req_snap.sv
// Request selector: freezes the request vector when told to, so the
// later arbitration stages work on one consistent picture.
// Assumes: load_i is asserted only while the bus is idle.
module bpa_req_snap #(
    parameter int N_PORTS = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [N_PORTS-1:0] req_i,
    output logic [N_PORTS-1:0] snap_o
);
    // Snapshot register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      snap_o <= '0;
        else if (load_i) snap_o <= req_i;
    end

    // A load with no request would start an arbitration with nothing to pick.
    p_load_has_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (req_i != '0));
endmodule

// File: rtl/bpa_prio_pick.sv
// Arbitration logic: fixed priority, lowest index wins.
// Assumes: IDX_W is wide enough to hold N_PORTS-1.
module bpa_prio_pick #(
    parameter int N_PORTS = 7,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] req_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               vld_o
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        for (int i = N_PORTS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
                vld_o = 1'b1;
            end
        end
    end

    // Mask of the bits below the picked index, used only by the check.
    logic [N_PORTS-1:0] below_mask;
    always_comb begin
        below_mask = '0;
        for (int j = 0; j < N_PORTS; j++)
            if (IDX_W'(j) < idx_o) below_mask[j] = 1'b1;
    end

    p_pick_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (req_i[idx_o] && ((req_i & below_mask) == '0)));
endmodule

// File: rtl/bpa_grant_fsm.sv
// Grant generator: runs the three-edge arbitration sequence and holds
// the grant of the winner until its request drops.
// Assumes: the winner index from the picker is derived from the snapshot.
module bpa_grant_fsm
    import bpa_pkg::*;
#(
    parameter int N_PORTS = 7,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] req_i,
    input  logic [IDX_W-1:0]   pick_idx_i,
    input  logic               pick_vld_i,
    output logic               snap_load_o,
    output logic [N_PORTS-1:0] grant_o,
    output logic               owner_vld_o
);
    localparam logic [N_PORTS-1:0] ONE = N_PORTS'(1);

    arb_st_e            st_q;
    logic [IDX_W-1:0]   win_q;
    logic [N_PORTS-1:0] pend_q;
    logic [N_PORTS-1:0] grant_q;

    // Snapshot is taken on the idle edge that sees any request.
    assign snap_load_o = (st_q == ST_IDLE) && (req_i != '0);

    // Sequencer and grant register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            win_q   <= '0;
            pend_q  <= '0;
            grant_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_i != '0) st_q <= ST_PICK;
                end
                ST_PICK: begin
                    win_q <= pick_idx_i;
                    st_q  <= pick_vld_i ? ST_BUILD : ST_IDLE;
                end
                ST_BUILD: begin
                    pend_q <= ONE << win_q;
                    st_q   <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    grant_q <= pend_q;
                    st_q    <= ST_OWN;
                end
                ST_OWN: begin
                    if (!req_i[win_q]) begin
                        grant_q <= '0;
                        st_q    <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign grant_o     = grant_q;
    assign owner_vld_o = (grant_q != '0);

    logic idle_with_req;
    assign idle_with_req = (st_q == ST_IDLE) && (req_i != '0);

    p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    p_grant_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owner_vld_o) |-> $past(idle_with_req, 4));

    p_grant_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_q & req_i) != '0) |=> $stable(grant_q));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_vld_o && ((grant_q & req_i) == '0)) |=> (grant_q == '0));
endmodule

// File: rtl/bpa_dest_decode.sv
// Address decoder: turns the owner's binary destination address into
// one select line per module; codes with no module select nothing.
// Assumes: the address is only meaningful while a grant is active.
module bpa_dest_decode #(
    parameter int N_PORTS = 7,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               owner_vld_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [N_PORTS-1:0] sel_o
);
    // One comparator per destination.
    for (genvar j = 0; j < N_PORTS; j++) begin : g_sel
        assign sel_o[j] = owner_vld_i && (addr_i == ADDR_W'(j));
    end

    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    p_sel_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(addr_i) >= N_PORTS) |-> (sel_o == '0));
endmodule

// File: rtl/bpa_bus_arbiter.sv
// Packet-granular shared bus arbiter: snapshot, fixed-priority pick,
// grant generation and destination decode for N_PORTS modules.
// Assumes: each owner holds its request high for its whole packet.
module bpa_bus_arbiter #(
    parameter int N_PORTS = 7,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] req_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    output logic [N_PORTS-1:0] grant_o,
    output logic [N_PORTS-1:0] dest_sel_o
);
    localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    logic               snap_load;
    logic [N_PORTS-1:0] snap;
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_vld;
    logic               owner_vld;

    bpa_req_snap #(.N_PORTS(N_PORTS)) u_snap (
        .clk(clk), .rst_n(rst_n), .load_i(snap_load),
        .req_i(req_i), .snap_o(snap)
    );

    bpa_prio_pick #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .req_i(snap),
        .idx_o(pick_idx), .vld_o(pick_vld)
    );

    bpa_grant_fsm #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .pick_idx_i(pick_idx), .pick_vld_i(pick_vld),
        .snap_load_o(snap_load), .grant_o(grant_o), .owner_vld_o(owner_vld)
    );

    bpa_dest_decode #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .owner_vld_i(owner_vld),
        .addr_i(bus_addr_i), .sel_o(dest_sel_o)
    );

    p_sel_needs_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_sel_o != '0) |-> (grant_o != '0));
endmodule

// File: tb/tb_bpa_bus_arbiter.sv
`timescale 1ns/100ps
module tb_bpa_bus_arbiter;
    localparam int N  = 7;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [AW-1:0] addr = '0;
    logic [N-1:0]  grant, dsel;

    int checks = 0, failures = 0;
    bit done = 0;

    // Behavioural model state.
    int           m_phase = 0;
    logic [N-1:0] m_snap = '0, m_grant = '0;
    int           m_win = 0;

    always #2.5 clk = ~clk;

    bpa_bus_arbiter #(.N_PORTS(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .bus_addr_i(addr),
        .grant_o(grant), .dest_sel_o(dsel)
    );

    task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_sel();
        logic [N-1:0] s = '0;
        if (m_grant != '0 && int'(addr) < N) s[addr] = 1'b1;
        return s;
    endfunction

    // One clock: advance the model from the inputs seen at the edge, then compare.
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            m_phase = 0; m_snap = '0; m_grant = '0; m_win = 0;
        end else begin
            case (m_phase)
                0: if (req != '0) begin m_snap = req; m_phase = 1; end
                1: begin
                    for (int i = N - 1; i >= 0; i--) if (m_snap[i]) m_win = i;
                    m_phase = 2;
                end
                2: m_phase = 3;
                3: begin m_grant = '0; m_grant[m_win] = 1'b1; m_phase = 4; end
                default: if (!req[m_win]) begin m_grant = '0; m_phase = 0; end
            endcase
        end
        #1;
        chk(grant == m_grant, "R2/R3 model grant", grant, m_grant);
        chk($onehot0(grant), "R5 one grant", grant, m_grant);
        chk(dsel == exp_sel(), "R7 model select", dsel, exp_sel());
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        // R1: reset clears everything.
        steps(2);
        chk(grant == '0, "R1 grant in reset", grant, '0);
        chk(dsel == '0, "R1 select in reset", dsel, '0);
        rst_n = 1'b1;
        steps(2);
        chk(grant == '0, "R5 no grant without request", grant, '0);

        // R2: exact latency for port 4.
        req = 7'b0010000;
        step();
        chk(grant == '0, "R2 low after sampling edge", grant, '0);
        steps(2);
        chk(grant == '0, "R2 low after edge k+2", grant, '0);
        step();
        chk(grant == 7'b0010000, "R2 grant after edge k+3", grant, 7'b0010000);

        // R7 / R8: decode.
        addr = 3'd2; #1;
        chk(dsel == 7'b0000100, "R7 select 2", dsel, 7'b0000100);
        addr = 3'd6; #1;
        chk(dsel == 7'b1000000, "R7 select 6", dsel, 7'b1000000);
        addr = 3'd7; #1;
        chk(dsel == '0, "R8 code 7 selects none", dsel, '0);
        step();

        // R6: release.
        req = '0;
        step();
        chk(grant == '0, "R6 grant drops on release", grant, '0);
        chk(dsel == '0, "R7 no select when idle", dsel, '0);
        steps(2);

        // R3: simultaneous requests 2, 5, 6.
        req = 7'b1100100; addr = 3'd0;
        steps(4);
        chk(grant == 7'b0000100, "R3 lowest index wins", grant, 7'b0000100);

        // R4: port 0 requests mid-packet.
        req = 7'b1100101;
        for (int i = 0; i < 6; i++) begin
            step();
            chk(grant == 7'b0000100, "R4 no preemption", grant, 7'b0000100);
        end

        // R6: owner drops; next arbitration starts on the next edge.
        req = 7'b1100001;
        step();
        chk(grant == '0, "R6 release", grant, '0);
        steps(3);
        chk(grant == '0, "R6 re-arbitration latency", grant, '0);
        step();
        chk(grant == 7'b0000001, "R3 port 0 wins next", grant, 7'b0000001);
        req = 7'b1100000;
        steps(5);
        chk(grant == 7'b0100000, "R3 port 5 after port 0", grant, 7'b0100000);

        // R9: late higher-priority request during arbitration.
        req = '0;
        steps(3);
        req = 7'b1000000;
        step();
        req = 7'b1000010;
        steps(3);
        chk(grant == 7'b1000000, "R9 snapshot winner kept", grant, 7'b1000000);
        req = 7'b0000010;
        steps(5);
        chk(grant == 7'b0000010, "R9 late requester served next", grant, 7'b0000010);

        // R1: reset in the middle of a packet.
        rst_n = 1'b0;
        step();
        chk(grant == '0, "R1 reset drops ownership", grant, '0);
        rst_n = 1'b1; req = '0;
        steps(3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule